// File: doc/BRIEF.md
# Cartridge Bus Gate and RAM-Enable Controller

This block sits on the cartridge side of an 8-bit handheld console bus with a 16-bit address. It decides when the cartridge's level-translating data transceiver may drive the console data bus. It also produces the chip select for the external battery-backed RAM, and it keeps a small RAM-enable register that console software writes.

The transceiver enable is gated by a full decode of the upper address bits. Because of this, the cartridge never drives the bus while console-internal memory is being read. The RAM select is also qualified by the enable register. Both outputs are combinational from the pins, so they add no latency at bus turnaround.

The enable register does not use a clock made from logic. The console strobe, address and data pins are brought into a free-running internal clock domain through two-flop synchronizers. The register then loads on the detected end of a decoded write strobe.

Top module: `cart_bus_ctrl`

## Requirements
- R1: `xcvr_oe_n` is 0 whenever at least one of `rd_n`, `wr_n`, `ain_n` is 0 and `addr_top[2]` (address bit 15) is 0, which is the ROM area.
- R2: `xcvr_oe_n` is 0 with a strobe low when `addr_top` (address bits 15..13) equals 3'b101, the external RAM area. With `addr_top` equal to 3'b100, 3'b110 or 3'b111 it stays 1 even while `rd_n` is 0.
- R3: With `rd_n`, `wr_n` and `ain_n` all at 1, `xcvr_oe_n` is 1 for every address.
- R4: `ram_cs_n` is 0 only when `cs_n` is 0, `addr_top[1]` (address bit 14) is 0, and the enable register holds 4'hA. Otherwise it is 1.
- R5: A write (`wr_n` low, then high) with `addr_top` = 3'b000 (range 0x0000–0x1FFF) loads `data[3:0]` into the enable register once the strobe has ended. Any value other than 4'hA disables the RAM.
- R6: Reads, AIN strobes and writes with `addr_top` other than 3'b000 leave the enable register unchanged. One write causes exactly one register update.
- R7: `rst_n` low asynchronously clears the synchronizers and the enable register, so `ram_cs_n` is 1 after reset.
- R8: `xcvr_oe_n` and `ram_cs_n` follow pin changes without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock, at least twice the bus cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Console read strobe, active low |
| wr_n | input | 1 | Console write strobe, active low |
| ain_n | input | 1 | Alternate write strobe, active low |
| cs_n | input | 1 | Console cartridge RAM-area select, active low |
| addr_top | input | 3 | Address bits 15..13 |
| data | input | 4 | Data bits 3..0 |
| xcvr_oe_n | output | 1 | Data transceiver output enable, active low |
| ram_cs_n | output | 1 | External RAM chip select, active low |

## Verification
The assertions assume that each strobe, and the address and data under it, stays stable for several internal clock periods. A shorter pulse may go unseen by the synchronizers and give no register update. The stimulus therefore holds every bus phase for ten internal clocks and changes address and data only while all strobes are high. Under these conditions, each write yields exactly one load.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int TOP_W = 3;

  // address bit 15 low: ROM area
  function automatic logic in_rom(input logic [TOP_W-1:0] a);
    return a[TOP_W-1] == 1'b0;
  endfunction

  // bits 15..13 = 101: external RAM area
  function automatic logic in_eram(input logic [TOP_W-1:0] a);
    return a == 3'b101;
  endfunction

  // bits 15..13 = 000: enable register range
  function automatic logic in_enable(input logic [TOP_W-1:0] a);
    return a == 3'b000;
  endfunction
endpackage

// File: rtl/cart_sync.sv
module cart_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= INIT;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cart_bus_gate.sv
module cart_bus_gate
  import cart_pkg::*;
(
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             ain_n,
  input  logic             cs_n,
  input  logic [TOP_W-1:0] addr_top,
  input  logic             ram_on,
  output logic             xcvr_oe_n,
  output logic             ram_cs_n
);
  logic any_strobe;
  logic owned;

  assign any_strobe = !rd_n || !wr_n || !ain_n;
  assign owned      = in_rom(addr_top) || in_eram(addr_top);
  assign xcvr_oe_n  = !(any_strobe && owned);
  assign ram_cs_n   = !(!cs_n && !addr_top[1] && ram_on);
endmodule

// File: rtl/cart_ram_enable.sv
module cart_ram_enable #(
  parameter int DW = 4,
  parameter logic [DW-1:0] KEY = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_s,
  input  logic [DW-1:0] data_s,
  output logic          load_pulse,
  output logic [DW-1:0] en_val,
  output logic          ram_on
);
  logic          strobe_q;
  logic [DW-1:0] data_hold;

  // the load fires when the decoded strobe goes from active to inactive
  assign load_pulse = strobe_q && !strobe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      data_hold <= '0;
      en_val    <= '0;
    end else begin
      strobe_q <= strobe_s;
      if (strobe_s) data_hold <= data_s;
      if (load_pulse) en_val <= data_hold;
    end
  end

  assign ram_on = (en_val == KEY);
endmodule

// File: rtl/cart_bus_ctrl.sv
module cart_bus_ctrl
  import cart_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] EN_KEY = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ain_n,
  input  logic              cs_n,
  input  logic [TOP_W-1:0]  addr_top,
  input  logic [DATA_W-1:0] data,
  output logic              xcvr_oe_n,
  output logic              ram_cs_n
);
  localparam int SW = 2 + TOP_W + DATA_W;

  logic [SW-1:0]     raw_bus, sync_bus;
  logic              rd_n_s, wr_n_s;
  logic [TOP_W-1:0]  addr_s;
  logic [DATA_W-1:0] data_s;
  logic              wr_strobe_s;
  logic              load_pulse;
  logic [DATA_W-1:0] en_val;
  logic              ram_on;

  assign raw_bus = {rd_n, wr_n, addr_top, data};

  cart_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT({2'b11, {(SW-2){1'b0}}})) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_bus), .dout(sync_bus)
  );

  assign {rd_n_s, wr_n_s, addr_s, data_s} = sync_bus;
  assign wr_strobe_s = !wr_n_s && rd_n_s && in_enable(addr_s);

  cart_ram_enable #(.DW(DATA_W), .KEY(EN_KEY)) u_en (
    .clk(clk), .rst_n(rst_n), .strobe_s(wr_strobe_s), .data_s(data_s),
    .load_pulse(load_pulse), .en_val(en_val), .ram_on(ram_on)
  );

  cart_bus_gate u_gate (
    .rd_n(rd_n), .wr_n(wr_n), .ain_n(ain_n), .cs_n(cs_n), .addr_top(addr_top),
    .ram_on(ram_on), .xcvr_oe_n(xcvr_oe_n), .ram_cs_n(ram_cs_n)
  );
endmodule

// File: rtl/cart_bus_ctrl_chk.sv
module cart_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ain_n,
  input logic       cs_n,
  input logic [2:0] addr_top,
  input logic       xcvr_oe_n,
  input logic       ram_cs_n,
  input logic       load_pulse,
  input logic [3:0] en_val
);
  // R1/R2: bus driven only inside cartridge-owned regions
  p_oe_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_oe_n |-> (!addr_top[2] || addr_top == 3'b101));
  // R3: no strobe, no drive
  p_oe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n && ain_n) |-> xcvr_oe_n);
  // R4: RAM select needs cs_n low and A14 low
  p_cs_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> (!cs_n && !addr_top[1]));
  // R5: register changes only following a load pulse
  p_load_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_val) |-> $past(load_pulse));
  // R6: one write, one load
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
endmodule

bind cart_bus_ctrl cart_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .ain_n(ain_n),
  .cs_n(cs_n), .addr_top(addr_top), .xcvr_oe_n(xcvr_oe_n),
  .ram_cs_n(ram_cs_n), .load_pulse(load_pulse), .en_val(en_val)
);

// File: tb/cart_bus_ctrl_tb.sv
module cart_bus_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1, ain_n = 1'b1, cs_n = 1'b1;
  logic [2:0] addr_top = 3'b000;
  logic [3:0] data = 4'h0;
  logic       xcvr_oe_n, ram_cs_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cart_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .ain_n(ain_n),
    .cs_n(cs_n), .addr_top(addr_top), .data(data),
    .xcvr_oe_n(xcvr_oe_n), .ram_cs_n(ram_cs_n)
  );

  // {rd_n, wr_n, ain_n, addr_top[2:0], expected xcvr_oe_n}
  localparam logic [6:0] VEC [14] = '{
    7'b0_1_1_000_0, 7'b0_1_1_011_0, 7'b1_0_1_001_0, 7'b1_1_0_010_0,
    7'b0_1_1_101_0, 7'b1_0_1_101_0, 7'b1_1_0_101_0,
    7'b0_1_1_100_1, 7'b0_1_1_110_1, 7'b0_1_1_111_1, 7'b1_0_1_110_1,
    7'b1_1_1_000_1, 7'b1_1_1_101_1, 7'b1_1_1_111_1
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [3:0] d);
    addr_top = a; data = d;
    cycles(10);
    wr_n = 1'b0;
    cycles(10);
    wr_n = 1'b1;
    cycles(10);
  endtask

  task automatic probe_cs(input logic exp, input string tag);
    addr_top = 3'b101; cs_n = 1'b0;
    #1 check(ram_cs_n, exp, tag);
    cs_n = 1'b1;
    cycles(2);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    // R7: reset state
    cs_n = 1'b0; addr_top = 3'b101;
    #1 check(ram_cs_n, 1'b1, "R7 cs during reset");
    cs_n = 1'b1;
    rst_n = 1'b1;
    cycles(3);
    probe_cs(1'b1, "R7 cs after reset");

    // R1 R2 R3 R8: vector walk, checked 1 ns after change with no clock edge
    foreach (VEC[k]) begin
      @(negedge clk);
      {rd_n, wr_n, ain_n, addr_top} = VEC[k][6:1];
      #1 check(xcvr_oe_n, VEC[k][0], $sformatf("R1/R2/R3/R8 vec %0d", k));
    end
    rd_n = 1'b1; wr_n = 1'b1; ain_n = 1'b1;
    cycles(3);

    // R5: enable with 0xA
    bus_write(3'b000, 4'hA);
    probe_cs(1'b0, "R5 enabled by 0xA");
    // R4: A14 high blocks select
    addr_top = 3'b010; cs_n = 1'b0;
    #1 check(ram_cs_n, 1'b1, "R4 A14 high");
    cs_n = 1'b1; cycles(2);
    // R8: cs follows cs_n immediately
    addr_top = 3'b101; cs_n = 1'b0;
    #1 check(ram_cs_n, 1'b0, "R8 cs_n low");
    cs_n = 1'b1;
    #1 check(ram_cs_n, 1'b1, "R4 cs_n high");
    cycles(2);

    // R6: read of enable range with data 0 does not load
    addr_top = 3'b000; data = 4'h0; cycles(5);
    rd_n = 1'b0; cycles(10); rd_n = 1'b1; cycles(10);
    probe_cs(1'b0, "R6 read ignored");
    // R6: AIN strobe in enable range does not load
    addr_top = 3'b000; data = 4'h0; cycles(5);
    ain_n = 1'b0; cycles(10); ain_n = 1'b1; cycles(10);
    probe_cs(1'b0, "R6 ain ignored");
    // R6: write outside enable range
    bus_write(3'b001, 4'h0);
    probe_cs(1'b0, "R6 write 0x2000 ignored");
    bus_write(3'b101, 4'h0);
    probe_cs(1'b0, "R6 write eram ignored");

    // R5: other value disables
    bus_write(3'b000, 4'h5);
    probe_cs(1'b1, "R5 disabled by 0x5");
    bus_write(3'b000, 4'hA);
    probe_cs(1'b0, "R5 re-enabled");
    bus_write(3'b000, 4'hB);
    probe_cs(1'b1, "R5 disabled by 0xB");
    bus_write(3'b000, 4'hA);

    // R5: register loads only after the strobe ends
    addr_top = 3'b000; data = 4'h0; cycles(5);
    wr_n = 1'b0; cycles(10);
    addr_top = 3'b101; cs_n = 1'b0;
    #1 check(ram_cs_n, 1'b0, "R5 no load while strobe held");
    cs_n = 1'b1; addr_top = 3'b000;
    @(negedge clk); wr_n = 1'b1; cycles(10);
    probe_cs(1'b1, "R5 load at strobe end");

    // R7: reset mid-run clears an enabled register
    bus_write(3'b000, 4'hA);
    probe_cs(1'b0, "R7 enabled before reset");
    rst_n = 1'b0; cycles(2); rst_n = 1'b1; cycles(3);
    probe_cs(1'b1, "R7 cleared by reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule